// File: doc/BRIEF.md
# Configurable SPI Master/Slave Character Engine

This block moves one character at a time over a four-wire style serial link, either as the bus master that produces the serial clock or as a slave that follows a clock arriving on its clock input pin. A single 16-bit mode word selects the role, the clock idle level, which edge launches and which edge captures data, the shift order, the character length, and the master's bit rate. The mode word is written and read through a simple register port and is zero after reset.

Software writes the mode word with the enable bit set, then offers a character on a valid/ready handshake. As master, the engine clocks the character out on MOSI while capturing MISO, then pulses `rx_valid` with the received character. A short idle gap follows each master character so that back-to-back traffic cannot exceed the rate limit. As slave, the offered character waits until the external master supplies clock edges. An internal loopback option feeds the transmit bit stream straight into the receiver, unchanged, and ignores the pin input.

Mode word layout: bit 15 reserved (always reads 0), bit 14 loopback, bit 13 clock idle level, bit 12 phase, bit 11 prescale-by-16 of the baud source, bit 10 MSB-first, bit 9 enable, bit 8 master (1) / slave (0), bits 7:4 prescale modulus PM, bits 3:0 length code LC.

Top module: `spi_char_engine`

## Requirements
- R1: After reset the mode word reads 0, `tx_ready`, `rx_valid`, `sck_out` and `mosi_out` are 0.
- R2: A write stores bits 14:0 of `cfg_wdata`; bit 15 always reads back as 0.
- R3: The master serial clock rests at the level of bit 13 (0 = low, 1 = high) before and after every character.
- R4: With bit 12 = 0 the first data bit is on the data line before the first clock edge, data is captured on edges leaving the idle level and changed on edges returning to it; with bit 12 = 1 data is changed on edges leaving the idle level and captured on edges returning to it.
- R5: With bit 10 = 0 characters are shifted least significant bit first in both directions; with bit 10 = 1 most significant bit first.
- R6: A character is LC+1 bits, with any value below 4 raised to 4; a master character makes exactly twice that many clock transitions.
- R7: The master half period is (PM+1) system clocks, multiplied by 16 when bit 11 is 1.
- R8: At the end of a master character `rx_valid` pulses for one cycle with the character captured from `miso_in`, right-aligned.
- R9: With bit 14 = 1 the received character equals the transmitted one and the data input pin is ignored.
- R10: In slave mode the engine shifts on edges of `sck_in`, receives on `mosi_in`, drives its character on `miso_out`, and reports the received character on `rx_valid`.
- R11: With the enable bit 0, `tx_ready` is 0, `sck_out` sits at the idle level, and an offered character starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_wdata | input | 16 | Mode word write data |
| cfg_rdata | output | 16 | Current mode word |
| tx_valid | input | 1 | Character offered for transfer |
| tx_data | input | 16 | Character to send, right-aligned |
| tx_ready | output | 1 | Engine can accept a character |
| rx_valid | output | 1 | One-cycle pulse, received character valid |
| rx_data | output | 16 | Received character, right-aligned |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_in | input | 1 | Serial clock received in slave mode |
| mosi_out | output | 1 | Master data out |
| mosi_in | input | 1 | Slave data in |
| miso_out | output | 1 | Slave data out |
| miso_in | input | 1 | Master data in |

## Verification
The hardest case to reach from the ports is the phase-1 format, where the first clock transition must not disturb the first data bit while every later transition of the same kind must advance it, so a bench that merely reads back received characters would not notice an off-by-one on the launch side. The bench therefore acts as the opposite end of the link: it watches every transition of the serial clock, checks the data line at each capture edge against the expected bit in the selected order, and launches its own reply bits on the opposite edge, for all eight combinations of idle level, phase and bit order. Loopback is driven with the complement of the transmitted character on the input pin so that any leak from the pin shows in the received value.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

   localparam int REG_W  = 16;
   localparam int DATA_W = 16;

   // Mode word, bit 15 down to bit 0
   typedef struct packed {
      logic       rsvd;
      logic       loop_back;
      logic       clk_pol;
      logic       clk_pha;
      logic       slow_src;
      logic       msb_first;
      logic       enable;
      logic       master;
      logic [3:0] prescale;
      logic [3:0] len_m1;
   } mode_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_TAIL = 2'd2
   } eng_state_t;

endpackage

// File: rtl/spi_eng_baud.sv
module spi_eng_baud #(
   parameter int PM_W   = 4,
   parameter int PREDIV = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            slow,
   input  logic [PM_W-1:0] pm,
   output logic            tick
);
   localparam int PRE_W = (PREDIV > 1) ? $clog2(PREDIV) : 1;
   localparam int GAP_W = PM_W + PRE_W + 1;

   if (PM_W < 1 || PREDIV < 1) begin : g_bad_cfg
      $error("spi_eng_baud: PM_W and PREDIV must be at least 1");
   end

   logic            pre_done;
   logic [PM_W-1:0] div_cnt;

   if (PREDIV > 1) begin : g_pre
      logic [PRE_W-1:0] pre_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               pre_cnt <= '0;
         else if (!run || !slow)                   pre_cnt <= '0;
         else if (pre_cnt == PRE_W'(PREDIV - 1))   pre_cnt <= '0;
         else                                      pre_cnt <= pre_cnt + 1'b1;
      end
      assign pre_done = !slow || (pre_cnt == PRE_W'(PREDIV - 1));
   end else begin : g_nopre
      assign pre_done = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             div_cnt <= '0;
      else if (!run)          div_cnt <= '0;
      else if (pre_done) begin
         if (div_cnt == pm)   div_cnt <= '0;
         else                 div_cnt <= div_cnt + 1'b1;
      end
   end

   assign tick = run && pre_done && (div_cnt == pm);

   // Interval checker for consecutive ticks
   logic [GAP_W-1:0] gap_cnt;
   logic             gap_seen;
   logic [GAP_W-1:0] gap_exp;
   assign gap_exp = (GAP_W'(pm) + GAP_W'(1)) * (slow ? GAP_W'(PREDIV) : GAP_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || !run) begin
         gap_cnt  <= '0;
         gap_seen <= 1'b0;
      end else if (tick) begin
         gap_cnt  <= '0;
         gap_seen <= 1'b1;
      end else begin
         gap_cnt  <= gap_cnt + 1'b1;
      end
   end

   assert_half_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && gap_seen) |-> ((gap_cnt + 1'b1) == gap_exp));

endmodule

// File: rtl/spi_eng_sync.sv
module spi_eng_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_pin,
   input  logic dat_pin,
   output logic sck_q,
   output logic dat_q
);
   if (STAGES < 2) begin : g_bad_cfg
      $error("spi_eng_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sck_pipe;
   logic [STAGES-1:0] dat_pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_pipe <= '0;
         dat_pipe <= '0;
      end else begin
         sck_pipe <= {sck_pipe[STAGES-2:0], sck_pin};
         dat_pipe <= {dat_pipe[STAGES-2:0], dat_pin};
      end
   end

   assign sck_q = sck_pipe[STAGES-1];
   assign dat_q = dat_pipe[STAGES-1];

endmodule

// File: rtl/spi_eng_shreg.sv
module spi_eng_shreg #(
   parameter int DATA_W   = 16,
   parameter int LEN_BITS = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [DATA_W-1:0]   load_char,
   input  logic                msb_first,
   input  logic [LEN_BITS-1:0] char_len,
   input  logic                launch,
   input  logic                sample,
   input  logic                din,
   output logic                dout,
   output logic [DATA_W-1:0]   rx_char
);
   if (DATA_W < 2 || (1 << (LEN_BITS - 1)) < DATA_W) begin : g_bad_cfg
      $error("spi_eng_shreg: LEN_BITS too small for DATA_W");
   end

   function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
      logic [DATA_W-1:0] r;
      for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
      return r;
   endfunction

   logic [DATA_W-1:0]   tx_sr;
   logic [DATA_W-1:0]   rx_sr;
   logic [LEN_BITS-1:0] pad;

   assign pad = LEN_BITS'(DATA_W) - char_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr <= '0;
         rx_sr <= '0;
      end else if (load) begin
         tx_sr <= msb_first ? (load_char << pad) : flip(load_char);
         rx_sr <= '0;
      end else begin
         if (launch) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
         if (sample) rx_sr <= {rx_sr[DATA_W-2:0], din};
      end
   end

   assign dout    = tx_sr[DATA_W-1];
   assign rx_char = msb_first ? rx_sr : (flip(rx_sr) >> pad);

endmodule

// File: rtl/spi_char_engine.sv
module spi_char_engine
   import spi_eng_pkg::*;
#(
   parameter int PREDIV      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_LEN     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_ready,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              sck_out,
   input  logic              sck_in,
   output logic              mosi_out,
   input  logic              mosi_in,
   output logic              miso_out,
   input  logic              miso_in
);
   localparam int LEN_BITS = $clog2(DATA_W) + 1;
   localparam int EDGE_W   = LEN_BITS + 1;
   localparam logic [REG_W-1:0] WR_MASK = {1'b0, {(REG_W-1){1'b1}}};

   if (MIN_LEN < 1 || MIN_LEN > DATA_W) begin : g_bad_len
      $error("spi_char_engine: MIN_LEN out of range");
   end

   mode_t               mode_q;
   eng_state_t          state;
   logic                sck_q, sck_prev;
   logic [EDGE_W-1:0]   edge_cnt;
   logic [LEN_BITS-1:0] len_raw, char_len;
   logic                en, is_master, tick, load;
   logic                sck_s, mosi_s;
   logic                edge_ev, new_level, leading, trailing;
   logic                sample_ev, launch_ev, last_edge;
   logic                dout, din;

   // Mode word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mode_q <= '0;
      else if (cfg_we) mode_q <= mode_t'(cfg_wdata & WR_MASK);
   end
   assign cfg_rdata = mode_q;
   assign en        = mode_q.enable;
   assign is_master = mode_q.master;

   assign len_raw  = LEN_BITS'(mode_q.len_m1) + LEN_BITS'(1);
   assign char_len = (len_raw < LEN_BITS'(MIN_LEN)) ? LEN_BITS'(MIN_LEN) : len_raw;

   // Baud generator, master only
   spi_eng_baud #(.PM_W(4), .PREDIV(PREDIV)) u_baud (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (en && is_master && (state != ST_IDLE)),
      .slow  (mode_q.slow_src),
      .pm    (mode_q.prescale),
      .tick  (tick)
   );

   // Slave pin synchroniser
   spi_eng_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .sck_pin (sck_in),
      .dat_pin (mosi_in),
      .sck_q   (sck_s),
      .dat_q   (mosi_s)
   );

   // Edge classification
   assign edge_ev   = (state == ST_RUN) && (is_master ? tick : (sck_s != sck_prev));
   assign new_level = is_master ? ~sck_q : sck_s;
   assign leading   = edge_ev && (new_level != mode_q.clk_pol);
   assign trailing  = edge_ev && (new_level == mode_q.clk_pol);
   assign sample_ev = mode_q.clk_pha ? trailing : leading;
   assign launch_ev = (mode_q.clk_pha ? leading : trailing) && (edge_cnt != '0);
   assign last_edge = edge_ev && (edge_cnt == ({char_len, 1'b0} - EDGE_W'(1)));

   assign tx_ready = en && (state == ST_IDLE);
   assign load     = tx_valid && tx_ready;

   // Sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sck_q    <= 1'b0;
         sck_prev <= 1'b0;
         edge_cnt <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         sck_prev <= sck_s;
         if (!en) begin
            state    <= ST_IDLE;
            sck_q    <= mode_q.clk_pol;
            edge_cnt <= '0;
         end else begin
            unique case (state)
               ST_IDLE: begin
                  sck_q    <= mode_q.clk_pol;
                  edge_cnt <= '0;
                  if (tx_valid) state <= ST_RUN;
               end
               ST_RUN: begin
                  if (edge_ev) begin
                     edge_cnt <= edge_cnt + 1'b1;
                     if (is_master) sck_q <= ~sck_q;
                     if (last_edge) begin
                        rx_valid <= 1'b1;
                        state    <= is_master ? ST_TAIL : ST_IDLE;
                     end
                  end
               end
               ST_TAIL: begin
                  if (tick) state <= ST_IDLE;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // Data path
   assign din = mode_q.loop_back ? dout : (is_master ? miso_in : mosi_s);

   spi_eng_shreg #(.DATA_W(DATA_W), .LEN_BITS(LEN_BITS)) u_shreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_char (tx_data),
      .msb_first (mode_q.msb_first),
      .char_len  (char_len),
      .launch    (launch_ev),
      .sample    (sample_ev),
      .din       (din),
      .dout      (dout),
      .rx_char   (rx_data)
   );

   assign sck_out  = (en && is_master) ? sck_q : mode_q.clk_pol;
   assign mosi_out = is_master ? dout : 1'b0;
   assign miso_out = is_master ? 1'b0 : dout;

   // Checks
   assert_tail_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TAIL) |-> (sck_out == mode_q.clk_pol));

   assert_edge_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN) |-> (edge_cnt < {char_len, 1'b0}));

   assert_rx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (state == ST_IDLE));

endmodule

// File: tb/spi_char_engine_bench.sv
module spi_char_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [15:0] cfg_wdata, cfg_rdata;
   logic        tx_valid, tx_ready, rx_valid;
   logic [15:0] tx_data, rx_data;
   logic        sck_out, sck_in, mosi_out, mosi_in, miso_out, miso_in;

   always #5 clk = ~clk;

   spi_char_engine u_spi_char_engine (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
      .sck_out(sck_out), .sck_in(sck_in), .mosi_out(mosi_out),
      .mosi_in(mosi_in), .miso_out(miso_out), .miso_in(miso_in)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] mk(bit lp, bit pol, bit pha, bit slow, bit msb,
                                      bit en, bit mst, logic [3:0] pm, logic [3:0] lm1);
      return {1'b0, lp, pol, pha, slow, msb, en, mst, pm, lm1};
   endfunction

   function automatic int eff_len(logic [3:0] lm1);
      int l = int'(lm1) + 1;
      return (l < 4) ? 4 : l;
   endfunction

   function automatic logic bitk(logic [15:0] c, int k, int len, bit msb);
      return msb ? c[len-1-k] : c[k];
   endfunction

   function automatic logic [15:0] lmask(int len);
      logic [31:0] m = (32'h1 << len) - 32'h1;
      return m[15:0];
   endfunction

   task automatic wr(input logic [15:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic offer(input logic [15:0] c);
      int g = 0;
      while (!tx_ready && g < 200) begin @(negedge clk); g++; end
      tx_valid = 1'b1; tx_data = c;
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   // Monitor: pops expected characters as the design reports them
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         if (exp_q.size() == 0) chk(1'b0, "R8 unexpected rx_valid", rx_data, 0);
         else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rx_data === e, t, rx_data, e);
         end
      end
   end

   task automatic master_xfer(input logic [15:0] mode, input logic [15:0] txc,
                              input logic [15:0] mc, input string tag);
      bit pol = mode[13], pha = mode[12], msb = mode[10], lp = mode[14];
      int len = eff_len(mode[3:0]);
      int hp  = (int'(mode[7:4]) + 1) * (mode[11] ? 16 : 1);
      int edges = 0, sidx = 0, midx = 0, bad_bits = 0, bad_gap = 0;
      int t = 0, last_t = 0, guard = 0, extra = 0;
      logic prev;
      wr(mode);
      miso_in = bitk(mc, 0, len, msb);
      @(negedge clk);
      chk(sck_out === pol, {tag, " R3 idle level"}, sck_out, pol);
      exp_q.push_back(lp ? (txc & lmask(len)) : (mc & lmask(len)));
      tag_q.push_back({tag, " R8 R9 rx char"});
      prev = pol;
      offer(txc);
      while (edges < 2 * len && guard < 20000) begin
         @(negedge clk);
         t++; guard++;
         if (sck_out !== prev) begin
            bit lead, samp;
            prev = sck_out;
            lead = (sck_out != pol);
            if (edges > 0 && (t - last_t) != hp) bad_gap++;
            last_t = t;
            edges++;
            samp = pha ? !lead : lead;
            if (samp) begin
               if (mosi_out !== bitk(txc, sidx, len, msb)) bad_bits++;
               sidx++;
            end else if (pha) begin
               miso_in = bitk(mc, midx, len, msb);
               midx++;
            end else begin
               midx++;
               if (midx < len) miso_in = bitk(mc, midx, len, msb);
            end
         end
      end
      chk(edges == 2 * len, {tag, " R6 edge count"}, edges, 2 * len);
      chk(bad_bits == 0, {tag, " R4 R5 mosi bits"}, bad_bits, 0);
      chk(bad_gap == 0, {tag, " R7 half period"}, bad_gap, 0);
      guard = 0;
      while (!tx_ready && guard < 2000) begin
         @(negedge clk);
         guard++;
         if (sck_out !== prev) begin extra++; prev = sck_out; end
      end
      chk(extra == 0, {tag, " R6 no extra edges"}, extra, 0);
      chk(sck_out === pol, {tag, " R3 rest level"}, sck_out, pol);
   endtask

   task automatic slave_xfer(input logic [15:0] mode, input logic [15:0] txc,
                             input logic [15:0] mc, input string tag);
      bit pol = mode[13], pha = mode[12], msb = mode[10], lp = mode[14];
      int len = eff_len(mode[3:0]);
      int sidx = 0, midx = 0, bad_bits = 0;
      wr(mode);
      sck_in  = pol;
      mosi_in = bitk(mc, 0, len, msb);
      repeat (6) @(negedge clk);
      exp_q.push_back(lp ? (txc & lmask(len)) : (mc & lmask(len)));
      tag_q.push_back({tag, " R10 R9 slave rx char"});
      offer(txc);
      repeat (4) @(negedge clk);
      for (int e = 0; e < 2 * len; e++) begin
         bit lead, samp;
         repeat (6) @(negedge clk);
         lead = (e % 2 == 0);
         samp = pha ? !lead : lead;
         if (samp) begin
            if (miso_out !== bitk(txc, sidx, len, msb)) bad_bits++;
            sidx++;
         end
         sck_in = ~sck_in;
         if (!samp) begin
            if (pha) begin
               mosi_in = bitk(mc, midx, len, msb);
               midx++;
            end else begin
               midx++;
               if (midx < len) mosi_in = bitk(mc, midx, len, msb);
            end
         end
      end
      repeat (10) @(negedge clk);
      chk(bad_bits == 0, {tag, " R10 R4 R5 miso bits"}, bad_bits, 0);
      chk(tx_ready === 1'b1, {tag, " R10 back to ready"}, tx_ready, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; tx_valid = 1'b0; tx_data = '0;
      sck_in = 1'b0; mosi_in = 1'b0; miso_in = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(cfg_rdata === 16'h0, "R1 mode word", cfg_rdata, 0);
      chk(tx_ready === 1'b0, "R1 tx_ready", tx_ready, 0);
      chk(rx_valid === 1'b0, "R1 rx_valid", rx_valid, 0);
      chk(sck_out === 1'b0, "R1 sck_out", sck_out, 0);
      chk(mosi_out === 1'b0, "R1 mosi_out", mosi_out, 0);

      // R2 readback and reserved bit
      wr(16'hFFFF);
      @(negedge clk);
      chk(cfg_rdata === 16'h7FFF, "R2 reserved bit", cfg_rdata, 16'h7FFF);
      wr(16'h1234 & ~16'h0200);
      @(negedge clk);
      chk(cfg_rdata === 16'h1034, "R2 readback", cfg_rdata, 16'h1034);

      // R11 disabled engine
      begin
         int sck_changes = 0, rx_seen = 0;
         logic p;
         wr(mk(0, 1, 0, 0, 1, 0, 1, 4'd1, 4'd7));
         @(negedge clk);
         chk(tx_ready === 1'b0, "R11 tx_ready while disabled", tx_ready, 0);
         chk(sck_out === 1'b1, "R11 idle level while disabled", sck_out, 1);
         p = sck_out;
         tx_valid = 1'b1; tx_data = 16'h00F0;
         for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (sck_out !== p) sck_changes++;
            if (rx_valid) rx_seen++;
         end
         tx_valid = 1'b0;
         chk(sck_changes == 0, "R11 no clock while disabled", sck_changes, 0);
         chk(rx_seen == 0, "R11 no result while disabled", rx_seen, 0);
      end

      // R3 R4 R5 R8: every idle level / phase / order combination
      for (int k = 0; k < 8; k++) begin
         logic [2:0] kb = 3'(k);
         master_xfer(mk(0, kb[2], kb[1], 0, kb[0], 1, 1, 4'd1, 4'd7),
                     16'h00A5 ^ 16'(k * 16'h0013), 16'h003C + 16'(k * 7),
                     $sformatf("combo%0d", k));
      end

      // R6 length codes including clamp
      master_xfer(mk(0, 0, 0, 0, 1, 1, 1, 4'd0, 4'd0), 16'h000B, 16'h0006, "R6 len code 0");
      master_xfer(mk(0, 1, 1, 0, 0, 1, 1, 4'd0, 4'd2), 16'hFFF9, 16'hFFF3, "R6 len code 2");
      master_xfer(mk(0, 0, 1, 0, 1, 1, 1, 4'd1, 4'd4), 16'h0016, 16'h0009, "R6 len 5");
      master_xfer(mk(0, 1, 0, 0, 0, 1, 1, 4'd0, 4'd15), 16'hC3A1, 16'h5E2D, "R6 len 16 lsb");
      master_xfer(mk(0, 0, 0, 0, 1, 1, 1, 4'd0, 4'd15), 16'h8001, 16'hB4C7, "R6 len 16 msb");

      // R7 divider settings
      master_xfer(mk(0, 0, 0, 0, 1, 1, 1, 4'd5, 4'd7), 16'h0081, 16'h007E, "R7 pm 5");
      master_xfer(mk(0, 1, 1, 1, 0, 1, 1, 4'd1, 4'd3), 16'h0005, 16'h000A, "R7 div16");

      // R9 loopback, pin driven with complement
      master_xfer(mk(1, 0, 0, 0, 1, 1, 1, 4'd1, 4'd9), 16'h02D3, ~16'h02D3, "R9 loop msb");
      master_xfer(mk(1, 1, 1, 0, 0, 1, 1, 4'd0, 4'd11), 16'h0A6C, ~16'h0A6C, "R9 loop lsb");

      // R10 slave
      slave_xfer(mk(0, 0, 0, 0, 1, 1, 0, 4'd0, 4'd7), 16'h00C5, 16'h005A, "R10 slave a");
      slave_xfer(mk(0, 1, 1, 0, 0, 1, 0, 4'd0, 4'd7), 16'h0093, 16'h0061, "R10 slave b");
      slave_xfer(mk(0, 0, 1, 0, 1, 1, 0, 4'd0, 4'd5), 16'h002E, 16'h0011, "R10 slave c");
      slave_xfer(mk(0, 1, 0, 0, 0, 1, 0, 4'd0, 4'd11), 16'h0B1D, 16'h04E2, "R10 slave d");
      slave_xfer(mk(1, 0, 0, 0, 1, 1, 0, 4'd0, 4'd7), 16'h0076, 16'h0089, "R9 slave loop");

      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "R8 every character delivered", exp_q.size(), 0);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule